// File: doc/BRIEF.md
# Clustered Operand Bypass Network

This block supplies the two source operands of every execution lane in an in-order multiple-issue pipeline whose lanes are split into clusters. For each operand it compares the source register index against the results that lanes offer from the end of execute and from writeback. It then hands the ALU the newest value without waiting for that value to be written to the register file and read back. Inside a cluster the operand mux sees the execute-stage and writeback-stage results of its own lanes directly. Results from other clusters reach it only through a copy registered one cycle later. This keeps the operand mux narrow.

Lane `i` belongs to cluster `i / (N/K)`. Within a pipeline stage a higher lane index is younger in program order. An execute-stage result is younger than any writeback-stage result. When a source index matches a result that another cluster is producing in the current cycle, and no own-cluster execute result covers it, the block raises a per-operand not-ready flag. The issue logic uses that flag to hold the instruction for one cycle. The ALUs, the register file and the steering of instructions to lanes are outside the block.

Top module: `clustered_bypass_net`

## Requirements
- R1: A source index of 0 always yields operand value 0 with the not-ready flag low, whatever any producer carries.
- R2: A valid execute-stage result of a lane in the same cluster whose destination equals the source index supplies the operand ahead of every other source.
- R3: With no same-cluster execute match, a valid same-cluster writeback-stage result with a matching destination supplies the operand ahead of remote and register-file values.
- R4: When several candidates at the same level match, the one from the highest lane index (the youngest) supplies the value. This holds for same-cluster execute, same-cluster writeback and the delayed remote level alike.
- R5: A valid execute-stage result of a lane in another cluster, presented in cycle t, supplies the operand in cycle t+1 when no same-cluster execute or writeback result matches.
- R6: The not-ready flag of an operand is 1 exactly when its index is nonzero, some other-cluster lane presents a matching valid execute-stage result in the current cycle, and no same-cluster execute-stage result matches.
- R7: With no match at any level, the operand is the register-file value presented for it.
- R8: A remote execute-stage result never supplies an operand in the cycle it is presented. The value then follows the remaining priority order.
- R9: Reset clears all delayed remote copies, so the first cycle after reset sees no delayed remote source.
- R10: A delayed remote copy is visible for exactly one cycle. If the remote lane presents no valid result in cycle t+1, nothing from it is seen in cycle t+2.
- R11: Results whose valid bit is low never match any operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| src_idx | input | N*2*IDX_W | Source register index per lane and operand slot |
| rf_val | input | N*2*DATA_W | Register-file read value per lane and operand slot |
| mx_vld | input | N | Execute-stage result valid per lane |
| mx_dst | input | N*IDX_W | Execute-stage destination index per lane |
| mx_val | input | N*DATA_W | Execute-stage result value per lane |
| wx_vld | input | N | Writeback-stage result valid per lane |
| wx_dst | input | N*IDX_W | Writeback-stage destination index per lane |
| wx_val | input | N*DATA_W | Writeback-stage result value per lane |
| opnd_val | output | N*2*DATA_W | Selected operand value per lane and operand slot |
| opnd_nrdy | output | N*2 | Operand not ready: a remote producer is still in flight |

## Verification
The bench builds the block at its defaults of four lanes in two clusters with 64-bit data and 5-bit indices. At that size every lane has both an own-cluster neighbour and two remote lanes. Directed cycles place producers at each priority level and at the same level in two lanes, and cover the one-cycle life of a delayed remote copy around reset. A long sweep then draws destination and source indices from 0 to 3 only, so that multiple matches, index 0 and simultaneous remote and local hits occur on most cycles. Every operand is compared against a model that tracks the previous cycle's execute results.

// File: rtl/cbn_pkg.sv
package cbn_pkg;
  parameter int unsigned CBN_DATA_W = 64;
  parameter int unsigned CBN_IDX_W  = 5;
  parameter int unsigned CBN_SRCS   = 2;

  // Winning source of an operand, in falling priority
  typedef enum logic [1:0] {
    SEL_LOC_MX  = 2'd0,
    SEL_LOC_WX  = 2'd1,
    SEL_REM_DLY = 2'd2,
    SEL_REGFILE = 2'd3
  } opnd_src_e;
endpackage

// File: rtl/byp_youngest_pick.sv
// Finds the highest-index (youngest) valid candidate whose tag matches key.
module byp_youngest_pick #(
  parameter int unsigned M  = 2,
  parameter int unsigned DW = 64,
  parameter int unsigned IW = 5
) (
  input  logic [M-1:0]         cand_vld,
  input  logic [M-1:0][IW-1:0] cand_dst,
  input  logic [M-1:0][DW-1:0] cand_val,
  input  logic [IW-1:0]        key,
  output logic                 hit,
  output logic [DW-1:0]        val
);
  always_comb begin
    hit = 1'b0;
    val = '0;
    for (int i = 0; i < int'(M); i++) begin
      if (cand_vld[i] && (key != '0) && (cand_dst[i] == key)) begin
        hit = 1'b1;
        val = cand_val[i];
      end
    end
  end
endmodule

// File: rtl/byp_remote_delay.sv
// One-cycle registered copy of every lane's execute-stage result.
module byp_remote_delay #(
  parameter int unsigned N  = 4,
  parameter int unsigned DW = 64,
  parameter int unsigned IW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         mx_vld,
  input  logic [N-1:0][IW-1:0] mx_dst,
  input  logic [N-1:0][DW-1:0] mx_val,
  output logic [N-1:0]         dly_vld,
  output logic [N-1:0][IW-1:0] dly_dst,
  output logic [N-1:0][DW-1:0] dly_val
);
  logic [N-1:0]         vld_q, vld_d;
  logic [N-1:0][IW-1:0] dst_q, dst_d;
  logic [N-1:0][DW-1:0] val_q, val_d;
  logic [N-1:0]         ld_en;

  assign ld_en = mx_vld;

  always_comb begin
    vld_d = mx_vld;
    dst_d = dst_q;
    val_d = val_q;
    for (int i = 0; i < int'(N); i++) begin
      if (ld_en[i]) begin
        dst_d[i] = mx_dst[i];
        val_d[i] = mx_val[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    dst_q <= dst_d;
    val_q <= val_d;
  end

  assign dly_vld = vld_q;
  assign dly_dst = dst_q;
  assign dly_val = val_q;

  for (genvar g = 0; g < N; g++) begin : g_chk
    // R5: a valid result reappears on the delayed path one cycle later
    p_dly_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mx_vld[g] |=> (dly_vld[g] && dly_dst[g] == $past(mx_dst[g])
                     && dly_val[g] == $past(mx_val[g])));
    // R10: the copy lives for one cycle only
    p_dly_expire_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !mx_vld[g] |=> !dly_vld[g]);
  end
endmodule

// File: rtl/byp_operand_sel.sv
// Operand selection for one source slot of one lane.
module byp_operand_sel
  import cbn_pkg::*;
#(
  parameter int unsigned LPC = 2,
  parameter int unsigned N   = 4,
  parameter int unsigned DW  = 64,
  parameter int unsigned IW  = 5
) (
  input  logic [IW-1:0]          src_idx,
  input  logic [DW-1:0]          rf_val,
  input  logic [LPC-1:0]         loc_mx_vld,
  input  logic [LPC-1:0][IW-1:0] loc_mx_dst,
  input  logic [LPC-1:0][DW-1:0] loc_mx_val,
  input  logic [LPC-1:0]         loc_wx_vld,
  input  logic [LPC-1:0][IW-1:0] loc_wx_dst,
  input  logic [LPC-1:0][DW-1:0] loc_wx_val,
  input  logic [N-1:0]           rem_dly_vld,
  input  logic [N-1:0][IW-1:0]   rem_dly_dst,
  input  logic [N-1:0][DW-1:0]   rem_dly_val,
  input  logic [N-1:0]           rem_mx_vld,
  input  logic [N-1:0][IW-1:0]   rem_mx_dst,
  output logic [DW-1:0]          opnd_val,
  output logic                   opnd_nrdy
);
  logic          lmx_hit, lwx_hit, rdly_hit, rmx_hit;
  logic [DW-1:0] lmx_val, lwx_val, rdly_val;
  opnd_src_e     sel;

  byp_youngest_pick #(.M(LPC), .DW(DW), .IW(IW)) u_pick_lmx (
    .cand_vld(loc_mx_vld), .cand_dst(loc_mx_dst), .cand_val(loc_mx_val),
    .key(src_idx), .hit(lmx_hit), .val(lmx_val));

  byp_youngest_pick #(.M(LPC), .DW(DW), .IW(IW)) u_pick_lwx (
    .cand_vld(loc_wx_vld), .cand_dst(loc_wx_dst), .cand_val(loc_wx_val),
    .key(src_idx), .hit(lwx_hit), .val(lwx_val));

  byp_youngest_pick #(.M(N), .DW(DW), .IW(IW)) u_pick_rdly (
    .cand_vld(rem_dly_vld), .cand_dst(rem_dly_dst), .cand_val(rem_dly_val),
    .key(src_idx), .hit(rdly_hit), .val(rdly_val));

  // Remote producer still in flight: tag compare only, no data path
  always_comb begin
    rmx_hit = 1'b0;
    for (int i = 0; i < int'(N); i++) begin
      if (rem_mx_vld[i] && (src_idx != '0) && (rem_mx_dst[i] == src_idx))
        rmx_hit = 1'b1;
    end
  end

  always_comb begin
    if      (lmx_hit)  sel = SEL_LOC_MX;
    else if (lwx_hit)  sel = SEL_LOC_WX;
    else if (rdly_hit) sel = SEL_REM_DLY;
    else               sel = SEL_REGFILE;
  end

  always_comb begin
    if (src_idx == '0) begin
      opnd_val = '0;
    end else begin
      unique case (sel)
        SEL_LOC_MX:  opnd_val = lmx_val;
        SEL_LOC_WX:  opnd_val = lwx_val;
        SEL_REM_DLY: opnd_val = rdly_val;
        default:     opnd_val = rf_val;
      endcase
    end
  end

  assign opnd_nrdy = rmx_hit && !lmx_hit;

  always_comb begin
    if (src_idx == '0)
      p_zero_idx_r1: assert (opnd_val == '0 && !opnd_nrdy);
    if (opnd_nrdy)
      p_nrdy_local_r6: assert (!lmx_hit && src_idx != '0);
    if (!lmx_hit && !lwx_hit && !rdly_hit && src_idx != '0)
      p_rf_fallback_r7: assert (opnd_val == rf_val);
  end
endmodule

// File: rtl/clustered_bypass_net.sv
module clustered_bypass_net
  import cbn_pkg::*;
#(
  parameter int unsigned N      = 4,
  parameter int unsigned K      = 2,
  parameter int unsigned DATA_W = CBN_DATA_W,
  parameter int unsigned IDX_W  = CBN_IDX_W
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [N-1:0][CBN_SRCS-1:0][IDX_W-1:0]  src_idx,
  input  logic [N-1:0][CBN_SRCS-1:0][DATA_W-1:0] rf_val,
  input  logic [N-1:0]                          mx_vld,
  input  logic [N-1:0][IDX_W-1:0]               mx_dst,
  input  logic [N-1:0][DATA_W-1:0]              mx_val,
  input  logic [N-1:0]                          wx_vld,
  input  logic [N-1:0][IDX_W-1:0]               wx_dst,
  input  logic [N-1:0][DATA_W-1:0]              wx_val,
  output logic [N-1:0][CBN_SRCS-1:0][DATA_W-1:0] opnd_val,
  output logic [N-1:0][CBN_SRCS-1:0]            opnd_nrdy
);
  localparam int unsigned LPC = N / K;

  if ((N % K) != 0) begin : g_bad_split
    $error("lane count must be a multiple of the cluster count");
  end

  logic [N-1:0]              dly_vld;
  logic [N-1:0][IDX_W-1:0]   dly_dst;
  logic [N-1:0][DATA_W-1:0]  dly_val;

  byp_remote_delay #(.N(N), .DW(DATA_W), .IW(IDX_W)) u_remote_dly (
    .clk(clk), .rst_n(rst_n),
    .mx_vld(mx_vld), .mx_dst(mx_dst), .mx_val(mx_val),
    .dly_vld(dly_vld), .dly_dst(dly_dst), .dly_val(dly_val));

  for (genvar c = 0; c < K; c++) begin : g_clu
    localparam logic [N-1:0] OWN_MASK = N'({LPC{1'b1}}) << (c * LPC);
    logic [N-1:0] rem_dly_vld, rem_mx_vld;
    assign rem_dly_vld = dly_vld & ~OWN_MASK;
    assign rem_mx_vld  = mx_vld  & ~OWN_MASK;

    for (genvar j = 0; j < LPC; j++) begin : g_lane
      for (genvar s = 0; s < CBN_SRCS; s++) begin : g_src
        byp_operand_sel #(.LPC(LPC), .N(N), .DW(DATA_W), .IW(IDX_W)) u_sel (
          .src_idx    (src_idx[c*LPC+j][s]),
          .rf_val     (rf_val[c*LPC+j][s]),
          .loc_mx_vld (mx_vld[c*LPC +: LPC]),
          .loc_mx_dst (mx_dst[c*LPC +: LPC]),
          .loc_mx_val (mx_val[c*LPC +: LPC]),
          .loc_wx_vld (wx_vld[c*LPC +: LPC]),
          .loc_wx_dst (wx_dst[c*LPC +: LPC]),
          .loc_wx_val (wx_val[c*LPC +: LPC]),
          .rem_dly_vld(rem_dly_vld),
          .rem_dly_dst(dly_dst),
          .rem_dly_val(dly_val),
          .rem_mx_vld (rem_mx_vld),
          .rem_mx_dst (mx_dst),
          .opnd_val   (opnd_val[c*LPC+j][s]),
          .opnd_nrdy  (opnd_nrdy[c*LPC+j][s]));
      end
    end
  end
endmodule

// File: tb/tb_clustered_bypass_net.sv
module tb_clustered_bypass_net;
  localparam int N = 4;
  localparam int K = 2;
  localparam int L = N / K;
  localparam int DW = 64;
  localparam int IW = 5;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0][1:0][IW-1:0] src_idx;
  logic [N-1:0][1:0][DW-1:0] rf_val;
  logic [N-1:0]              mx_vld, wx_vld;
  logic [N-1:0][IW-1:0]      mx_dst, wx_dst;
  logic [N-1:0][DW-1:0]      mx_val, wx_val;
  logic [N-1:0][1:0][DW-1:0] opnd_val;
  logic [N-1:0][1:0]         opnd_nrdy;

  // model of the previous cycle's execute results
  logic [N-1:0]         pv_vld;
  logic [N-1:0][IW-1:0] pv_dst;
  logic [N-1:0][DW-1:0] pv_val;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [63:0] rs = 64'h9E37_79B9_7F4A_7C15;

  always #(CLK_P/2) clk = ~clk;

  clustered_bypass_net #(.N(N), .K(K), .DATA_W(DW), .IDX_W(IW)) dut (
    .clk(clk), .rst_n(rst_n), .src_idx(src_idx), .rf_val(rf_val),
    .mx_vld(mx_vld), .mx_dst(mx_dst), .mx_val(mx_val),
    .wx_vld(wx_vld), .wx_dst(wx_dst), .wx_val(wx_val),
    .opnd_val(opnd_val), .opnd_nrdy(opnd_nrdy));

  function automatic logic [63:0] rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 7);
    rs = rs ^ (rs << 17);
    return rs;
  endfunction

  // expected operand from the requirements
  task automatic model(input int l, input int s, output logic [DW-1:0] ev,
                       output logic en, output string t);
    int c = l / L;
    logic [IW-1:0] k = src_idx[l][s];
    logic lmx = 0, lwx = 0, rd = 0, rmx = 0;
    logic [DW-1:0] vmx = 0, vwx = 0, vrd = 0;
    for (int j = c*L; j < c*L+L; j++) begin
      if (mx_vld[j] && mx_dst[j] == k) begin lmx = 1; vmx = mx_val[j]; end
      if (wx_vld[j] && wx_dst[j] == k) begin lwx = 1; vwx = wx_val[j]; end
    end
    for (int j = 0; j < N; j++) begin
      if (j / L != c) begin
        if (pv_vld[j] && pv_dst[j] == k) begin rd = 1; vrd = pv_val[j]; end
        if (mx_vld[j] && mx_dst[j] == k) rmx = 1;
      end
    end
    if (k == 0) begin ev = 0; en = 0; t = "R1"; end
    else begin
      en = rmx && !lmx;
      if (lmx)     begin ev = vmx; t = "R2/R4"; end
      else if (lwx) begin ev = vwx; t = "R3/R4"; end
      else if (rd)  begin ev = vrd; t = "R5"; end
      else          begin ev = rf_val[l][s]; t = "R7"; end
      if (en) t = {t, "+R6/R8"};
    end
  endtask

  // compare all operands a quarter period after the drive edge, then
  // record the execute results the design captures at the coming edge
  task automatic check_all(input string tag);
    logic [DW-1:0] ev;
    logic en;
    string t;
    #(CLK_P/4);
    for (int l = 0; l < N; l++) begin
      for (int s = 0; s < 2; s++) begin
        model(l, s, ev, en, t);
        n_chk++;
        if (opnd_val[l][s] !== ev || opnd_nrdy[l][s] !== en) begin
          n_bad++;
          $display("FAIL %s (%s) lane %0d src %0d: got val=%h nrdy=%b exp val=%h nrdy=%b",
                   tag, t, l, s, opnd_val[l][s], opnd_nrdy[l][s], ev, en);
        end
      end
    end
    if (rst_n) begin pv_vld = mx_vld; pv_dst = mx_dst; pv_val = mx_val; end
    else       pv_vld = '0;
    @(negedge clk);
  endtask

  task automatic clear_inputs();
    mx_vld = '0; wx_vld = '0; mx_dst = '0; wx_dst = '0;
    for (int l = 0; l < N; l++) begin
      mx_val[l] = 64'hA000_0000_0000_0000 | 64'(l);
      wx_val[l] = 64'hB000_0000_0000_0000 | 64'(l);
      for (int s = 0; s < 2; s++) begin
        src_idx[l][s] = 5'(l*2 + s + 10);
        rf_val[l][s] = 64'hF000_0000_0000_0000 | 64'(l*16 + s);
      end
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    pv_vld = '0; pv_dst = '0; pv_val = '0;
    clear_inputs();
    // R9: a remote producer during reset leaves nothing behind
    mx_vld[2] = 1; mx_dst[2] = 5'd3;
    @(negedge clk);
    check_all("R9 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    clear_inputs();
    src_idx[0][0] = 5'd3;
    check_all("R9 first cycle after reset");

    // R7: no producers at all
    check_all("R7 idle");

    // R1: index 0 with producers targeting 0
    mx_vld = '1; wx_vld = '1;
    for (int l = 0; l < N; l++) src_idx[l] = '0;
    check_all("R1 index zero");
    clear_inputs();

    // R2 and R4: two own-cluster execute matches, younger lane wins
    mx_vld[0] = 1; mx_dst[0] = 5'd5;
    mx_vld[1] = 1; mx_dst[1] = 5'd5;
    wx_vld[1] = 1; wx_dst[1] = 5'd5;
    src_idx[0][0] = 5'd5; src_idx[1][1] = 5'd5;
    check_all("R2 R4 local execute");
    clear_inputs();

    // R3 and R4: two own-cluster writeback matches
    wx_vld[2] = 1; wx_dst[2] = 5'd6;
    wx_vld[3] = 1; wx_dst[3] = 5'd6;
    src_idx[2][0] = 5'd6; src_idx[3][1] = 5'd6;
    check_all("R3 R4 local writeback");
    clear_inputs();

    // R6/R8, then R5, then R10
    mx_vld[2] = 1; mx_dst[2] = 5'd7;
    mx_vld[3] = 1; mx_dst[3] = 5'd7;
    src_idx[0][0] = 5'd7; src_idx[1][1] = 5'd7;
    check_all("R6 R8 remote in flight");
    clear_inputs();
    src_idx[0][0] = 5'd7; src_idx[1][1] = 5'd7;
    check_all("R5 R4 delayed remote");
    check_all("R10 delayed copy expired");

    // R11: invalid producers with matching tags
    mx_dst = {N{5'd9}}; wx_dst = {N{5'd9}};
    for (int l = 0; l < N; l++) src_idx[l] = {5'd9, 5'd9};
    check_all("R11 invalid producers");

    // dense sweep over a small index range
    for (int cyc = 0; cyc < 4000; cyc++) begin
      logic [63:0] r;
      for (int l = 0; l < N; l++) begin
        r = rnd();
        mx_vld[l] = r[0]; wx_vld[l] = r[1];
        mx_dst[l] = 5'(r[3:2]); wx_dst[l] = 5'(r[5:4]);
        src_idx[l][0] = 5'(r[7:6]); src_idx[l][1] = 5'(r[9:8]);
        mx_val[l] = rnd(); wx_val[l] = rnd();
        rf_val[l][0] = rnd(); rf_val[l][1] = rnd();
      end
      check_all("sweep R1-R11");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule